// File: doc/BRIEF.md
# Multiplexed DRAM Address Controller

This controller turns a single-cycle host request into the strobe sequence a DRAM with a shared address bus expects. The host gives a full word address, a read/write flag and, for a write, the data word. The controller splits the address into two halves. The upper half is the row. The lower half is the column. Both halves go out, one after the other, on one narrow address bus. The controller then drives the active-low row strobe, column strobe and write enable in a fixed order.

Each phase lasts a parameterised number of clock cycles. A single down-counter times every phase. This lets the same RTL meet a device's row-to-column, column-access and precharge times at any host clock rate. A read samples the device's data output in the last cycle the column strobe is low. A write keeps the word on the data-to-device bus. It releases the row strobe before the column strobe, so that the modified row is written back. The host sees `busy` for the whole operation and a one-cycle `done` at its end.

Top module: `dram_addr_ctrl`

## Requirements
- R1: During and directly after reset, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are 1, `busy` and `done` are 0 and `rd_data` is 0.
- R2: The row half, `req_addr[2*AW-1:AW]`, is on `mem_addr` when `mem_ras_n` falls. The bus holds that value through the cycle before the fall. `mem_ras_n` falls T_ROW cycles after the accepting clock edge.
- R3: The column half, `req_addr[AW-1:0]`, is on `mem_addr` when `mem_cas_n` falls. `mem_cas_n` falls only while `mem_ras_n` is low, and T_RCD+T_COL cycles after the row strobe fell.
- R4: In a write, `mem_we_n` falls T_RCD cycles after `mem_ras_n` falls, which is before `mem_cas_n` falls. `mem_ras_n` rises T_CAS cycles after `mem_cas_n` falls, while `mem_cas_n` is still low. `mem_cas_n` and `mem_we_n` rise together one cycle later.
- R5: In a read, `mem_we_n` stays 1 for the whole operation. `mem_ras_n` and `mem_cas_n` rise in the same cycle, T_CAS cycles after `mem_cas_n` fell. `rd_data` takes the value of `mem_rdata` from the last cycle in which `mem_cas_n` is low.
- R6: During a write, `mem_wdata` carries the accepted `req_wdata` while `mem_cas_n` is low, so the addressed word then holds that value.
- R7: A request is accepted only while `busy` is 0. A `req_valid` pulse while `busy` is 1 starts no access, changes no stored word, and leaves all strobes at 1 once the current operation ends.
- R8: `busy` is 1 from the cycle after acceptance for exactly T_ROW+T_RCD+T_COL+T_CAS+T_PRE cycles on a read, and one cycle more on a write.
- R9: `done` is 1 for exactly one cycle, the first cycle after `busy` falls. On a read, `rd_data` holds the word read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Word address, row in upper half, column in lower half |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last word read |
| mem_addr | output | AW | Multiplexed row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wdata | output | DW | Data to the device |
| mem_rdata | input | DW | Data from the device |

## Verification
The hardest case to reach is a request that arrives while an access is already running. A design that accepts it would corrupt a second word, and the host cannot see that at the moment it happens. The bench raises `req_valid` in the middle of a write, with a different address and data. It then watches the strobes stay high after `done`. Finally it reads the intruder's address back and compares the word with the value the bench predicts independently. Strobe edges are timed by sampling every cycle of each operation, which covers both orderings at the release: row strobe before column strobe for a write, both together for a read.

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int T_ROW = 2,
  parameter int T_RCD = 2,
  parameter int T_COL = 1,
  parameter int T_CAS = 2,
  parameter int T_PRE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ras_n,
  output logic          mem_cas_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(T_ROW + T_RCD + T_COL + T_CAS + T_PRE + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_WB, S_PRE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          op_wr;
  logic [AW-1:0] row_q, col_q;
  logic [DW-1:0] wdata_q;
  logic          last;
  logic          col_phase;

  assign last      = (cnt == '0);
  assign col_phase = (state == S_COL) || (state == S_CAS) || (state == S_WB);

  assign busy      = (state != S_IDLE);
  assign mem_ras_n = !((state == S_RAS) || (state == S_COL) || (state == S_CAS));
  assign mem_cas_n = !((state == S_CAS) || (state == S_WB));
  assign mem_we_n  = !(op_wr && col_phase);
  assign mem_addr  = col_phase ? col_q : row_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      op_wr   <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_wr   <= req_write;
          row_q   <= req_addr[2*AW-1:AW];
          col_q   <= req_addr[AW-1:0];
          wdata_q <= req_wdata;
          cnt     <= CW'(T_ROW - 1);
          state   <= S_ROW;
        end
        S_ROW: if (last) begin
          cnt   <= CW'(T_RCD - 1);
          state <= S_RAS;
        end else cnt <= cnt - 1'b1;
        S_RAS: if (last) begin
          cnt   <= CW'(T_COL - 1);
          state <= S_COL;
        end else cnt <= cnt - 1'b1;
        S_COL: if (last) begin
          cnt   <= CW'(T_CAS - 1);
          state <= S_CAS;
        end else cnt <= cnt - 1'b1;
        S_CAS: if (last) begin
          if (!op_wr) rd_data <= mem_rdata;
          cnt   <= CW'(T_PRE - 1);
          state <= op_wr ? S_WB : S_PRE;
        end else cnt <= cnt - 1'b1;
        S_WB: state <= S_PRE;
        S_PRE: if (last) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dram_addr_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n
);
  // R2
  row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> $stable(mem_addr));
  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> !mem_ras_n);
  // R4
  we_leads_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && !mem_we_n) |-> $past(!mem_we_n));
  // R4
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ras_n) && !mem_we_n) |-> (!mem_cas_n ##1 (mem_cas_n && mem_we_n)));
  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ras_n) && mem_we_n) |-> mem_cas_n);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ras_n && mem_cas_n && mem_we_n));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind dram_addr_ctrl dram_addr_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n)
);

// File: tb/dram_addr_ctrl_test.sv
module dram_addr_ctrl_test;
  localparam int AW = 5, DW = 8;
  localparam int T_ROW = 2, T_RCD = 2, T_COL = 1, T_CAS = 2, T_PRE = 2;
  localparam int WORDS = 1 << (2 * AW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ras_n, mem_cas_n, mem_we_n;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_addr_ctrl #(.AW(AW), .DW(DW), .T_ROW(T_ROW), .T_RCD(T_RCD), .T_COL(T_COL),
                   .T_CAS(T_CAS), .T_PRE(T_PRE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  logic [DW-1:0] cells [0:WORDS-1];
  logic [DW-1:0] shadow [0:WORDS-1];
  logic [AW-1:0] m_row, m_col;

  always @(negedge mem_ras_n) m_row = mem_addr;
  always @(negedge mem_cas_n) begin
    m_col = mem_addr;
    if (!mem_we_n) cells[{m_row, mem_addr}] = mem_wdata;
  end
  assign mem_rdata = (!mem_cas_n && mem_we_n) ? cells[{m_row, m_col}] : 'z;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reset_test();
    repeat (2) @(negedge clk);
    chk("R1 strobes", {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
    chk("R1 busy/done", {busy, done}, 2'b00);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {mem_ras_n, mem_cas_n, mem_we_n, busy, done}, 5'b11100);
  endtask

  task automatic run_op(input bit wr, input logic [2*AW-1:0] a, input logic [DW-1:0] d,
                        input bit intrude, input logic [2*AW-1:0] ia);
    int ras_f = -1, ras_r = -1, cas_f = -1, cas_r = -1, we_f = -1, we_r = -1;
    int busy_cnt = 0, done_at = -1;
    logic [AW-1:0] row_seen = '0, col_seen = '0;
    logic [DW-1:0] got = '0;
    logic pr = 1'b1, pc = 1'b1, pw = 1'b1;
    int base = T_ROW + T_RCD + T_COL + T_CAS;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int n = 1; n < 64 && done_at < 0; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (intrude && n == 4) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = ia; req_wdata = ~d;
      end
      if (intrude && n == 5) req_valid = 1'b0;
      if (busy) busy_cnt++;
      if (pr && !mem_ras_n) begin ras_f = n; row_seen = mem_addr; end
      if (!pr && mem_ras_n) ras_r = n;
      if (pc && !mem_cas_n) begin cas_f = n; col_seen = mem_addr; end
      if (!pc && mem_cas_n) cas_r = n;
      if (pw && !mem_we_n) we_f = n;
      if (!pw && mem_we_n) we_r = n;
      if (done) begin done_at = n; got = rd_data; end
      pr = mem_ras_n; pc = mem_cas_n; pw = mem_we_n;
    end
    chk("R2 ras fall cycle", ras_f, T_ROW + 1);
    chk("R2 row half", int'(row_seen), int'(a[2*AW-1:AW]));
    chk("R3 cas fall cycle", cas_f, T_ROW + T_RCD + T_COL + 1);
    chk("R3 column half", int'(col_seen), int'(a[AW-1:0]));
    if (wr) begin
      chk("R4 we fall", we_f, T_ROW + T_RCD + 1);
      chk("R4 ras rise", ras_r, base + 1);
      chk("R4 cas rise", cas_r, base + 2);
      chk("R4 we rise", we_r, base + 2);
      chk("R6 word stored", int'(cells[a]), int'(d));
      shadow[a] = d;
    end else begin
      chk("R5 we idle", we_f, -1);
      chk("R5 ras rise", ras_r, base + 1);
      chk("R5 cas rise", cas_r, base + 1);
      chk("R5 rd_data", int'(got), int'(shadow[a]));
    end
    chk("R8 busy length", busy_cnt, base + T_PRE + (wr ? 1 : 0));
    chk("R9 done cycle", done_at, base + T_PRE + (wr ? 1 : 0) + 1);
    @(negedge clk);
    chk("R9 done single", {done, busy}, 2'b00);
    chk("R7 strobes idle", {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
    if (!wr) chk("R9 rd_data held", int'(rd_data), int'(shadow[a]));
  endtask

  task automatic write_patterns();
    run_op(1'b1, 10'h000, 8'hA5, 1'b0, '0);
    run_op(1'b1, 10'h3FF, 8'h5A, 1'b0, '0);
    run_op(1'b1, 10'h2AA, 8'hFF, 1'b0, '0);
    run_op(1'b1, 10'h155, 8'h00, 1'b0, '0);
  endtask

  task automatic read_patterns();
    run_op(1'b0, 10'h000, '0, 1'b0, '0);
    run_op(1'b0, 10'h3FF, '0, 1'b0, '0);
    run_op(1'b0, 10'h2AA, '0, 1'b0, '0);
    run_op(1'b0, 10'h155, '0, 1'b0, '0);
    run_op(1'b0, 10'h0E3, '0, 1'b0, '0);
  endtask

  task automatic busy_request_test();
    run_op(1'b1, 10'h071, 8'h3C, 1'b1, 10'h18E);
    repeat (4) begin
      @(negedge clk);
      chk("R7 no second access", {mem_ras_n, mem_cas_n, busy}, 3'b110);
    end
    chk("R7 intruder word untouched", int'(cells[10'h18E]), int'(shadow[10'h18E]));
    run_op(1'b0, 10'h18E, '0, 1'b0, '0);
    run_op(1'b0, 10'h071, '0, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      cells[i] = DW'(i * 7 + 3);
      shadow[i] = DW'(i * 7 + 3);
    end
    reset_test();
    write_patterns();
    read_patterns();
    busy_request_test();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule